// File: doc/BRIEF.md
# Receive descriptor ring DMA engine

This block takes one Ethernet frame at a time from a byte stream and stores it in host memory by walking a ring of receive descriptors. It holds a pointer to the current descriptor. For each descriptor it reads the four 32-bit words through a single-outstanding word memory port and checks that the DMA owns it. It then packs the frame bytes, little-endian, into the descriptor's buffers, writes the status word back and moves on to the next descriptor.

A descriptor either carries two independent buffers, or it carries one buffer and uses its fourth word as the address of the next descriptor. An end-of-ring flag sends the walk back to the base address. Four zero bytes are appended to every frame to stand in for the frame check sequence. A 3-bit process state reports progress, and two single-cycle pulses report completion and a missing descriptor.

Top module: `rx_desc_dma`

## Requirements
- R1: When a frame starts while the current-descriptor pointer is zero, the pointer is first loaded from `base_addr`, and the descriptor at that address is fetched.
- R2: If the first descriptor fetched for a frame has bit 31 of word 0 clear (not owned by the DMA), the block pulses `unavail_pulse` and `irq_pulse` together and reports state 4 (suspended). It consumes and drops the whole frame without any memory write and leaves the pointer unchanged.
- R3: The byte count stored is the frame length plus FCS_BYTES (default 4) zero bytes. Bytes are packed four per word, the first byte in bits 7:0. A partial last word has its unused bytes written as zero. The count is written to bits 29:16 of the status word.
- R4: Buffer 1 (address in word 2, size in word 1 bits 10:0) is filled first. Buffer 2 (address in word 3, size in word 1 bits 21:11) is used only when the chained bit (word 1 bit 24) is clear and frame bytes remain.
- R5: The next descriptor address is `base_addr` if the end-of-ring bit (word 1 bit 25) is set. Otherwise it is word 3 if the chained bit is set. Otherwise it is the current address plus 16.
- R6: Write-back puts into word 0: bit 31 cleared, bit 9 set in the first descriptor of the frame, bit 8 set in the final one, and the cumulative byte count in bits 29:16.
- R7: If a follow-on descriptor is not owned, the frame ends in the previous descriptor. That descriptor gets bit 8, plus the error bit 14 unless `flush_on` is high. The rest of the frame is discarded and the pointer moves to the unowned descriptor.
- R8: After the final descriptor is written back, `irq_pulse` is high for exactly one cycle unless that descriptor's word 1 bit 31 (completion interrupt disable) is set. The state then becomes 3 (waiting).
- R9: `state_o` encodes 0 stopped (idle with `rx_enable` low), 1 fetching, 7 transferring, 5 closing, 3 waiting and 4 suspended. A frame passes through 1, 7 and 5.
- R10: A memory request holds its valid, direction, address and write data stable until `mem_req_ready` accepts it.
- R11: While the block is idle with `rx_enable` low, `s_ready` stays low and no frame is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 32 | Descriptor ring base address |
| rx_enable | input | 1 | Receive enable; frames start only while high |
| flush_on | input | 1 | Suppresses the descriptor error flag when a follow-on descriptor is missing |
| s_valid | input | 1 | Frame byte valid |
| s_data | input | 8 | Frame byte |
| s_last | input | 1 | Marks the final byte of the frame |
| s_ready | output | 1 | Byte accepted when high together with s_valid |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a word write, 0 for a word read |
| mem_req_addr | output | 32 | Byte address of the word |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_rdata | input | 32 | Read data |
| state_o | output | 3 | Receive process state |
| irq_pulse | output | 1 | Single-cycle receive interrupt |
| unavail_pulse | output | 1 | Single-cycle descriptor-unavailable indication |
| cur_desc_o | output | 32 | Current descriptor pointer |

## Verification
The bench builds the block with the default FCS_BYTES of 4 and attaches a 1 KiB word memory model. The model can hold off `mem_req_ready` on alternate cycles. Buffer sizes of 4, 6 and 8 bytes make short frames cross buffer and descriptor boundaries, so every padding byte and the cumulative length can be checked word by word. The descriptor chain covers all three next-address choices and both owned and unowned follow-on descriptors, with and without flush.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    localparam int WORD_BYTES = 4;
    localparam int FILL_W     = 3;
    localparam int LEN_W      = 14;
    localparam int SIZE_W     = 11;

    // status word fields
    localparam int OWN_BIT   = 31;
    localparam int LEN_LSB   = 16;
    localparam int ERR_BIT   = 14;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT  = 8;

    // control word fields
    localparam int SZ2_LSB   = 11;
    localparam int CHAIN_BIT = 24;
    localparam int EOR_BIT   = 25;
    localparam int NOIRQ_BIT = 31;

    localparam logic [31:0] DESC_STRIDE = 32'd16;

    typedef enum logic [2:0] {
        PS_STOPPED = 3'd0,
        PS_FETCH   = 3'd1,
        PS_WAIT    = 3'd3,
        PS_SUSP    = 3'd4,
        PS_CLOSE   = 3'd5,
        PS_XFER    = 3'd7
    } proc_e;

    typedef enum logic [2:0] {
        S_IDLE, S_FREQ, S_FRSP, S_ACC, S_WR, S_WBMID, S_CLOSE, S_DRAIN
    } fsm_e;

    typedef struct packed {
        logic              noirq;
        logic              eor;
        logic              chain;
        logic [SIZE_W-1:0] sz2;
        logic [SIZE_W-1:0] sz1;
    } ctl_t;

    typedef struct packed {
        logic [31:0] addr;
        logic        first;
        logic        noirq;
        logic [31:0] nxt;
    } wb_t;

    function automatic ctl_t decode_ctl(input logic [31:0] w);
        ctl_t c;
        c.noirq = w[NOIRQ_BIT];
        c.eor   = w[EOR_BIT];
        c.chain = w[CHAIN_BIT];
        c.sz2   = w[SZ2_LSB +: SIZE_W];
        c.sz1   = w[SIZE_W-1:0];
        return c;
    endfunction

    function automatic logic [31:0] next_desc(input logic [31:0] cur,
                                              input logic [31:0] base,
                                              input ctl_t        c,
                                              input logic [31:0] w3);
        if (c.eor)        return base;
        else if (c.chain) return w3;
        else              return cur + DESC_STRIDE;
    endfunction

    function automatic logic [31:0] status_word(input logic [LEN_W-1:0] len,
                                                input logic first,
                                                input logic last,
                                                input logic err);
        logic [31:0] w;
        w = '0;
        w[LEN_LSB +: LEN_W] = len;
        w[FIRST_BIT] = first;
        w[LAST_BIT]  = last;
        w[ERR_BIT]   = err;
        return w;
    endfunction

endpackage

// File: rtl/rxd_packer.sv
module rxd_packer
    import rxd_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic                      clear,
    input  logic [7:0]                byte_in,
    output logic [WORD_BYTES*8-1:0]   word,
    output logic [FILL_W-1:0]         fill
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            word <= '0;
            fill <= '0;
        end else if (push) begin
            word[{fill, 3'b000} +: 8] <= byte_in;
            fill <= fill + 1'b1;
        end
    end

endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
    import rxd_pkg::*;
#(
    parameter int FCS_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       base_addr,
    input  logic              rx_enable,
    input  logic              flush_on,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    input  logic              s_last,
    output logic              s_ready,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [31:0]       mem_req_addr,
    output logic [31:0]       mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [31:0]       mem_rsp_rdata,
    output logic [2:0]        state_o,
    output logic              irq_pulse,
    output logic              unavail_pulse,
    output logic [31:0]       cur_desc_o,
    output logic              pk_push,
    output logic              pk_clear,
    output logic [7:0]        pk_byte,
    input  logic [31:0]       pk_word,
    input  logic [FILL_W-1:0] pk_fill
);

    localparam int PAD_W = $clog2(FCS_BYTES + 1);

    fsm_e              st;
    proc_e             proc;
    ctl_t              ctl;
    wb_t               wb;
    logic [31:0]       cur_desc, desc_addr, w2, w3, wr_addr;
    logic              own, first_fetch, first_of_frame;
    logic              stream_done, frame_done, buf_sel, err;
    logic [1:0]        idx;
    logic [SIZE_W-1:0] space;
    logic [PAD_W-1:0]  pad_left;
    logic [LEN_W-1:0]  total;

    logic        stream_take, pad_take, last_byte, fetch_done;
    logic [31:0] start_ptr, nd;

    assign s_ready     = (st == S_ACC && !stream_done && space != '0) || st == S_DRAIN;
    assign stream_take = s_valid && s_ready;
    assign pad_take    = st == S_ACC && stream_done && space != '0 && pad_left != '0;
    assign last_byte   = pad_take && pad_left == PAD_W'(1);
    assign pk_push     = st == S_ACC && (stream_take || pad_take);
    assign pk_byte     = stream_done ? 8'h00 : s_data;
    assign pk_clear    = st == S_WR && mem_req_ready;
    assign fetch_done  = st == S_FRSP && mem_rsp_valid && idx == 2'd3;
    assign start_ptr   = (cur_desc == '0) ? base_addr : cur_desc;
    assign nd          = next_desc(desc_addr, base_addr, ctl, w3);

    assign unavail_pulse = fetch_done && first_fetch && !own;
    assign irq_pulse     = (st == S_CLOSE && mem_req_ready && !wb.noirq) || unavail_pulse;
    assign state_o       = proc;
    assign cur_desc_o    = cur_desc;

    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b1;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        unique case (st)
            S_FREQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b0;
                mem_req_addr  = desc_addr + {28'd0, idx, 2'b00};
            end
            S_WR: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = wr_addr;
                mem_req_wdata = pk_word;
            end
            S_WBMID: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = wb.addr;
                mem_req_wdata = status_word(total, wb.first, 1'b0, 1'b0);
            end
            S_CLOSE: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = wb.addr;
                mem_req_wdata = status_word(total, wb.first, 1'b1, err);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st             <= S_IDLE;
            proc           <= PS_STOPPED;
            ctl            <= '0;
            wb             <= '0;
            cur_desc       <= '0;
            desc_addr      <= '0;
            w2             <= '0;
            w3             <= '0;
            wr_addr        <= '0;
            own            <= 1'b0;
            first_fetch    <= 1'b0;
            first_of_frame <= 1'b0;
            stream_done    <= 1'b0;
            frame_done     <= 1'b0;
            buf_sel        <= 1'b0;
            err            <= 1'b0;
            idx            <= '0;
            space          <= '0;
            pad_left       <= '0;
            total          <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (!rx_enable) begin
                        proc <= PS_STOPPED;
                    end else if (s_valid) begin
                        cur_desc       <= start_ptr;
                        desc_addr      <= start_ptr;
                        first_fetch    <= 1'b1;
                        first_of_frame <= 1'b1;
                        stream_done    <= 1'b0;
                        frame_done     <= 1'b0;
                        pad_left       <= PAD_W'(FCS_BYTES);
                        total          <= '0;
                        err            <= 1'b0;
                        idx            <= '0;
                        proc           <= PS_FETCH;
                        st             <= S_FREQ;
                    end else if (proc == PS_STOPPED) begin
                        proc <= PS_WAIT;
                    end
                end
                S_FREQ: if (mem_req_ready) st <= S_FRSP;
                S_FRSP: if (mem_rsp_valid) begin
                    unique case (idx)
                        2'd0: own <= mem_rsp_rdata[OWN_BIT];
                        2'd1: ctl <= decode_ctl(mem_rsp_rdata);
                        2'd2: w2  <= mem_rsp_rdata;
                        default: w3 <= mem_rsp_rdata;
                    endcase
                    idx <= idx + 1'b1;
                    if (idx != 2'd3) begin
                        st <= S_FREQ;
                    end else if (first_fetch) begin
                        if (!own) begin
                            proc <= PS_SUSP;
                            st   <= S_DRAIN;
                        end else begin
                            wr_addr <= w2;
                            space   <= ctl.sz1;
                            buf_sel <= 1'b0;
                            proc    <= PS_XFER;
                            st      <= S_ACC;
                        end
                    end else if (own) begin
                        proc <= PS_XFER;
                        st   <= S_WBMID;
                    end else begin
                        err  <= !flush_on;
                        proc <= PS_CLOSE;
                        st   <= S_CLOSE;
                    end
                end
                S_ACC: begin
                    if (space == '0) begin
                        if (!buf_sel && !ctl.chain) begin
                            buf_sel <= 1'b1;
                            wr_addr <= w3;
                            space   <= ctl.sz2;
                        end else begin
                            wb             <= '{addr: desc_addr, first: first_of_frame,
                                                noirq: ctl.noirq, nxt: nd};
                            desc_addr      <= nd;
                            first_of_frame <= 1'b0;
                            first_fetch    <= 1'b0;
                            idx            <= '0;
                            proc           <= PS_FETCH;
                            st             <= S_FREQ;
                        end
                    end else if (stream_take || pad_take) begin
                        space <= space - 1'b1;
                        total <= total + 1'b1;
                        if (stream_take && s_last) stream_done <= 1'b1;
                        if (pad_take) pad_left <= pad_left - 1'b1;
                        if (pk_fill == FILL_W'(WORD_BYTES - 1) || space == SIZE_W'(1) || last_byte) begin
                            frame_done <= last_byte;
                            st         <= S_WR;
                        end
                    end
                end
                S_WR: if (mem_req_ready) begin
                    wr_addr <= wr_addr + 32'd4;
                    if (frame_done) begin
                        wb   <= '{addr: desc_addr, first: first_of_frame,
                                  noirq: ctl.noirq, nxt: nd};
                        proc <= PS_CLOSE;
                        st   <= S_CLOSE;
                    end else begin
                        st <= S_ACC;
                    end
                end
                S_WBMID: if (mem_req_ready) begin
                    wr_addr <= w2;
                    space   <= ctl.sz1;
                    buf_sel <= 1'b0;
                    st      <= S_ACC;
                end
                S_CLOSE: if (mem_req_ready) begin
                    cur_desc <= wb.nxt;
                    proc     <= PS_WAIT;
                    st       <= stream_done ? S_IDLE : S_DRAIN;
                end
                default: if (s_valid && s_last) st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
    import rxd_pkg::*;
#(
    parameter int FCS_BYTES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] base_addr,
    input  logic        rx_enable,
    input  logic        flush_on,
    input  logic        s_valid,
    input  logic [7:0]  s_data,
    input  logic        s_last,
    output logic        s_ready,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic        mem_req_write,
    output logic [31:0] mem_req_addr,
    output logic [31:0] mem_req_wdata,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_rdata,
    output logic [2:0]  state_o,
    output logic        irq_pulse,
    output logic        unavail_pulse,
    output logic [31:0] cur_desc_o
);

    logic              pk_push, pk_clear;
    logic [7:0]        pk_byte;
    logic [31:0]       pk_word;
    logic [FILL_W-1:0] pk_fill;

    rxd_ctrl #(.FCS_BYTES(FCS_BYTES)) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .base_addr     (base_addr),
        .rx_enable     (rx_enable),
        .flush_on      (flush_on),
        .s_valid       (s_valid),
        .s_data        (s_data),
        .s_last        (s_last),
        .s_ready       (s_ready),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_write (mem_req_write),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_rdata (mem_rsp_rdata),
        .state_o       (state_o),
        .irq_pulse     (irq_pulse),
        .unavail_pulse (unavail_pulse),
        .cur_desc_o    (cur_desc_o),
        .pk_push       (pk_push),
        .pk_clear      (pk_clear),
        .pk_byte       (pk_byte),
        .pk_word       (pk_word),
        .pk_fill       (pk_fill)
    );

    rxd_packer u_packer (
        .clk     (clk),
        .rst     (rst),
        .push    (pk_push),
        .clear   (pk_clear),
        .byte_in (pk_byte),
        .word    (pk_word),
        .fill    (pk_fill)
    );

endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_ready,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic        mem_req_write,
    input logic [31:0] mem_req_addr,
    input logic [31:0] mem_req_wdata,
    input logic [2:0]  state_o,
    input logic        irq_pulse,
    input logic        unavail_pulse
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_write)
            && $stable(mem_req_addr) && $stable(mem_req_wdata)); // R10

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse); // R8

    AST_CLOSE_TO_WAIT: assert property (@(posedge clk) disable iff (rst)
        irq_pulse && !unavail_pulse |=> state_o == 3'd3); // R8

    AST_UNAVAIL_IRQ: assert property (@(posedge clk) disable iff (rst)
        unavail_pulse |-> irq_pulse); // R2

    AST_UNAVAIL_SUSP: assert property (@(posedge clk) disable iff (rst)
        unavail_pulse |=> state_o == 3'd4); // R2

    AST_SUSP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd4 |-> !(mem_req_valid && mem_req_write)); // R2

    AST_STOP_NO_READY: assert property (@(posedge clk) disable iff (rst)
        state_o == 3'd0 |-> !s_ready); // R11

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        state_o != 3'd2 && state_o != 3'd6); // R9

endmodule

bind rx_desc_dma rx_desc_dma_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .s_ready       (s_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .state_o       (state_o),
    .irq_pulse     (irq_pulse),
    .unavail_pulse (unavail_pulse)
);

// File: tb/rx_desc_dma_tb.sv
`timescale 1ns/1ps
module rx_desc_dma_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] base_addr = 32'h100;
    logic        rx_enable = 1'b0;
    logic        flush_on = 1'b0;
    logic        s_valid = 1'b0;
    logic [7:0]  s_data = '0;
    logic        s_last = 1'b0;
    logic        s_ready;
    logic        mem_req_valid, mem_req_write, mem_req_ready;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_rdata;
    logic [2:0]  state_o;
    logic        irq_pulse, unavail_pulse;
    logic [31:0] cur_desc_o;

    logic [31:0] mem [0:255];
    logic        ld_en = 1'b0;
    logic [31:0] ld_addr = '0, ld_data = '0;
    logic        stall_en = 1'b0;
    logic        stall_tgl;
    int          wr_cnt, irq_cnt, ua_cnt;
    logic [7:0]  seen;
    logic        seen_clr = 1'b0;
    int          errors = 0, checks = 0;

    always #10 clk = ~clk;

    assign mem_req_ready = stall_en ? stall_tgl : 1'b1;

    rx_desc_dma u_dut (
        .clk(clk), .rst(rst), .base_addr(base_addr), .rx_enable(rx_enable),
        .flush_on(flush_on), .s_valid(s_valid), .s_data(s_data), .s_last(s_last),
        .s_ready(s_ready), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .state_o(state_o), .irq_pulse(irq_pulse),
        .unavail_pulse(unavail_pulse), .cur_desc_o(cur_desc_o)
    );

    // memory model, one-cycle read latency
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= 32'hDEADBEEF;
            mem_rsp_valid <= 1'b0;
            mem_rsp_rdata <= '0;
            stall_tgl <= 1'b0;
            wr_cnt <= 0; irq_cnt <= 0; ua_cnt <= 0;
        end else begin
            stall_tgl <= ~stall_tgl;
            mem_rsp_valid <= mem_req_valid && mem_req_ready && !mem_req_write;
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr[9:2]] <= mem_req_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    mem_rsp_rdata <= mem[mem_req_addr[9:2]];
                end
            end
            if (ld_en) mem[ld_addr[9:2]] <= ld_data;
            if (irq_pulse) irq_cnt <= irq_cnt + 1;
            if (unavail_pulse) ua_cnt <= ua_cnt + 1;
        end
    end

    always @(negedge clk) begin
        if (seen_clr) seen <= '0;
        else seen[state_o] <= 1'b1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        poke(a, w0); poke(a + 4, w1); poke(a + 8, w2); poke(a + 12, w3);
    endtask

    task automatic clear_seen();
        @(negedge clk); seen_clr = 1'b1;
        @(negedge clk); seen_clr = 1'b0;
    endtask

    task automatic send_frame(input int n, input logic [7:0] first);
        logic hs;
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            s_valid = 1'b1;
            s_data  = first + 8'(k);
            s_last  = (k == n - 1);
            do begin
                #1 hs = s_ready;
                @(posedge clk);
                @(negedge clk);
            end while (!hs);
        end
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 reset state stopped", 32'(state_o), 32'd0);
        chk("R11 reset s_ready low", 32'(s_ready), 32'd0);
        chk("R10 reset no request", 32'(mem_req_valid), 32'd0);
        chk("R1 reset pointer zero", cur_desc_o, 32'd0);
    endtask

    task automatic t_basic();
        int i0;
        put_desc(32'h100, 32'h8000_0000, 32'h0000_0040, 32'h200, 32'h0);
        rx_enable = 1'b1;
        clear_seen();
        i0 = irq_cnt;
        send_frame(10, 8'h10);
        repeat (60) @(negedge clk);
        chk("R3 word0", mem[8'h80], 32'h1312_1110);
        chk("R3 word1", mem[8'h81], 32'h1716_1514);
        chk("R3 word2 pad", mem[8'h82], 32'h0000_1918);
        chk("R3 word3 pad", mem[8'h83], 32'h0000_0000);
        chk("R3 no extra word", mem[8'h84], 32'hDEADBEEF);
        chk("R6 status", mem[8'h40], 32'h000E_0300);
        chk("R1 pointer from base then R5 +16", cur_desc_o, 32'h110);
        chk("R8 irq once", 32'(irq_cnt - i0), 32'd1);
        chk("R9 waiting", 32'(state_o), 32'd3);
        chk("R9 saw fetching", 32'(seen[1]), 32'd1);
        chk("R9 saw transferring", 32'(seen[7]), 32'd1);
        chk("R9 saw closing", 32'(seen[5]), 32'd1);
    endtask

    task automatic t_two_buffers();
        int i0;
        put_desc(32'h110, 32'h8000_0000, 32'h8002_0006, 32'h240, 32'h280);
        i0 = irq_cnt;
        send_frame(8, 8'h20);
        repeat (60) @(negedge clk);
        chk("R4 buf1 word0", mem[8'h90], 32'h2322_2120);
        chk("R4 buf1 word1", mem[8'h91], 32'h0000_2524);
        chk("R4 buf1 limit", mem[8'h92], 32'hDEADBEEF);
        chk("R4 buf2 word0", mem[8'hA0], 32'h0000_2726);
        chk("R4 buf2 word1", mem[8'hA1], 32'h0000_0000);
        chk("R6 status two buffers", mem[8'h44], 32'h000C_0300);
        chk("R8 irq disabled", 32'(irq_cnt - i0), 32'd0);
        chk("R5 sequential next", cur_desc_o, 32'h120);
    endtask

    task automatic t_chain_ring();
        int i0;
        put_desc(32'h120, 32'h8000_0000, 32'h0100_2808, 32'h2A0, 32'h180);
        put_desc(32'h180, 32'h8000_0000, 32'h0200_0010, 32'h2C0, 32'h0);
        i0 = irq_cnt;
        send_frame(6, 8'h30);
        repeat (80) @(negedge clk);
        chk("R4 chained buf word0", mem[8'hA8], 32'h3332_3130);
        chk("R4 chained buf word1", mem[8'hA9], 32'h0000_3534);
        chk("R4 chained buf2 unused", mem[8'hAA], 32'hDEADBEEF);
        chk("R3 pad in second desc", mem[8'hB0], 32'h0000_0000);
        chk("R3 second desc limit", mem[8'hB1], 32'hDEADBEEF);
        chk("R6 first desc not last", mem[8'h48], 32'h0008_0200);
        chk("R6 last desc cumulative", mem[8'h60], 32'h000A_0100);
        chk("R5 end of ring wraps", cur_desc_o, 32'h100);
        chk("R8 irq chained", 32'(irq_cnt - i0), 32'd1);
    endtask

    task automatic t_unowned_first();
        int i0, u0, w0;
        i0 = irq_cnt; u0 = ua_cnt; w0 = wr_cnt;
        send_frame(5, 8'h70);
        repeat (20) @(negedge clk);
        chk("R2 unavailable pulse", 32'(ua_cnt - u0), 32'd1);
        chk("R2 irq with unavailable", 32'(irq_cnt - i0), 32'd1);
        chk("R2 no writes", 32'(wr_cnt - w0), 32'd0);
        chk("R2 suspended", 32'(state_o), 32'd4);
        chk("R2 pointer kept", cur_desc_o, 32'h100);
    endtask

    task automatic t_followon_missing();
        int i0;
        flush_on = 1'b0;
        put_desc(32'h100, 32'h8000_0000, 32'h0000_0004, 32'h300, 32'h0);
        i0 = irq_cnt;
        send_frame(10, 8'h40);
        repeat (40) @(negedge clk);
        chk("R7 data before stop", mem[8'hC0], 32'h4342_4140);
        chk("R7 nothing beyond", mem[8'hC1], 32'hDEADBEEF);
        chk("R7 status with error", mem[8'h40], 32'h0004_4300);
        chk("R7 unowned desc untouched", mem[8'h44], 32'h000C_0300);
        chk("R7 pointer at unowned", cur_desc_o, 32'h110);
        chk("R7 irq", 32'(irq_cnt - i0), 32'd1);
        chk("R7 waiting", 32'(state_o), 32'd3);
        flush_on = 1'b1;
        put_desc(32'h110, 32'h8000_0000, 32'h0000_0004, 32'h320, 32'h0);
        send_frame(7, 8'h50);
        repeat (40) @(negedge clk);
        chk("R7 flush data", mem[8'hC8], 32'h5352_5150);
        chk("R7 flush no error", mem[8'h44], 32'h0004_0300);
        chk("R7 flush pointer", cur_desc_o, 32'h120);
    endtask

    task automatic t_disabled();
        int w0, rdy;
        rx_enable = 1'b0;
        w0 = wr_cnt; rdy = 0;
        @(negedge clk);
        s_valid = 1'b1; s_data = 8'hAA; s_last = 1'b1;
        repeat (10) begin
            @(negedge clk);
            if (s_ready) rdy++;
        end
        chk("R11 ready held low", 32'(rdy), 32'd0);
        chk("R9 stopped", 32'(state_o), 32'd0);
        chk("R11 no writes", 32'(wr_cnt - w0), 32'd0);
        s_valid = 1'b0; s_last = 1'b0;
        rx_enable = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 waiting on enable", 32'(state_o), 32'd3);
    endtask

    task automatic t_stall();
        put_desc(32'h120, 32'h8000_0000, 32'h0000_0040, 32'h340, 32'h0);
        stall_en = 1'b1;
        send_frame(3, 8'h60);
        repeat (100) @(negedge clk);
        stall_en = 1'b0;
        chk("R10 stalled word0", mem[8'hD0], 32'h0062_6160);
        chk("R10 stalled word1", mem[8'hD1], 32'h0000_0000);
        chk("R10 stalled status", mem[8'h48], 32'h0007_0300);
        chk("R10 stalled pointer", cur_desc_o, 32'h130);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_two_buffers();
        t_chain_ring();
        t_unowned_first();
        t_followon_missing();
        t_disabled();
        t_stall();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule